// File: doc/BRIEF.md
# Receive Frame Statistics Classifier

This block sits between a receive MAC and the per-port statistics counters. When a frame ends, the MAC presents the frame's status for one cycle. That status holds the address-match result, the byte length, the three receive error flags, an overrun flag and the destination address. The classifier decides whether the frame is good and whether it is a good broadcast frame. One cycle later it raises a one-cycle increment strobe on the line of the port that received the frame.

A frame is good when four conditions hold. The address filter accepted it, either by a unicast, broadcast or multicast match or by promiscuous acceptance. Its length lies between 64 bytes and the configured maximum, both ends included. It has no CRC error, no alignment error and no code error. The overrun flag takes no part in the decision. A good frame whose 48-bit destination address is all ones also counts as a good broadcast. A strobe appears only on ports whose statistics enable bit is set when the frame ends.

Control is a two-state machine. ST_IDLE means no strobe is pending. ST_EMIT means a verdict captured on the previous edge is being presented. The four transitions are these: T_CAPTURE goes from ST_IDLE to ST_EMIT on end-of-frame. T_CHAIN stays in ST_EMIT on a back-to-back end-of-frame. T_RETIRE goes from ST_EMIT to ST_IDLE when no new frame ends. T_WAIT stays in ST_IDLE.

Top module: `rxs_frame_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of good_strobe and bcast_strobe is 0.
- R2: A frame ending in cycle N with eof_valid high produces its strobes in cycle N+1 only. A frame ending in cycle N+1 gives its own verdict in cycle N+2, so back-to-back frames each get exactly one strobe cycle.
- R3: Four match_code values accept a frame: 1 (unicast), 2 (broadcast), 3 (multicast) and 4 (promiscuous). Code 0 and codes 5 to 7 reject it.
- R4: A frame is good only if 64 <= frame_len <= max_len. Lengths 63 and max_len+1 are not good.
- R5: A frame with crc_err, align_err or code_err set, alone or in any combination, is not good.
- R6: The overrun input has no effect on either strobe.
- R7: bcast_strobe bit p is 1 exactly when good_strobe bit p is 1 and dest_addr was 48'hFFFF_FFFF_FFFF at end of frame, whatever the match code.
- R8: A strobe appears on port p only if port_en bit p was 1 at end of frame. An eof_port value of NUM_PORTS or more produces no strobe.
- R9: max_len, port_en and all status inputs are sampled in the end-of-frame cycle. Changing them in the strobe cycle does not alter the strobe.
- R10: good_strobe has at most one bit set, and that bit is the one selected by eof_port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_valid | input | 1 | End-of-frame status valid, one cycle per frame |
| eof_port | input | 2 | Receiving port index |
| match_code | input | 3 | Address filter result: 0 none, 1 unicast, 2 broadcast, 3 multicast, 4 promiscuous |
| frame_len | input | 14 | Frame length in bytes |
| max_len | input | 14 | Largest good length in bytes |
| crc_err | input | 1 | CRC error flag |
| align_err | input | 1 | Alignment error flag |
| code_err | input | 1 | Code error flag |
| overrun | input | 1 | Overrun flag, ignored by the classifier |
| dest_addr | input | 48 | Destination address |
| port_en | input | 3 | Statistics enable, one bit per port |
| good_strobe | output | 3 | Good-frame increment, one bit per port |
| bcast_strobe | output | 3 | Good-broadcast increment, one bit per port |

## Verification
The hardest situation to reach is a frame ending while the previous frame's strobe is still on the outputs. Here the state machine must stay in ST_EMIT and swap in the new verdict without losing or merging either frame. The bench drives end-of-frame on two consecutive cycles with opposite verdicts and on different ports, then checks each strobe cycle on its own. A second case changes max_len and port_en in the strobe cycle itself, to show that the verdict was frozen at end of frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    // Smallest length, in bytes, that a good frame may have.
    localparam int MIN_GOOD_LEN = 64;

    // Result codes presented by the address filter.
    typedef enum logic [2:0] {
        MATCH_NONE      = 3'd0,
        MATCH_UNICAST   = 3'd1,
        MATCH_BROADCAST = 3'd2,
        MATCH_MULTICAST = 3'd3,
        MATCH_PROMISC   = 3'd4
    } rxs_match_e;

    // Classifier control states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rxs_state_e;

    // Verdict captured at end of frame.
    typedef struct packed {
        logic good;
        logic bcast;
    } rxs_verdict_t;

endpackage

// File: rtl/rxs_len_window.sv
module rxs_len_window
    import rxs_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] max_len,
    output logic             too_short,
    output logic             too_long,
    output logic             in_window
);

    localparam logic [LEN_W-1:0] LOW_BOUND = LEN_W'(MIN_GOOD_LEN);

    always_comb begin
        too_short = (frame_len < LOW_BOUND);
        too_long  = (frame_len > max_len);
        in_window = !too_short && !too_long;
    end

endmodule

// File: rtl/rxs_error_screen.sv
module rxs_error_screen #(
    parameter int ERR_N = 3
) (
    input  logic [ERR_N-1:0] err_flags,
    output logic             clean
);

    // Reduce the error flags one stage at a time so ERR_N can grow.
    logic [ERR_N:0] any_err;

    assign any_err[0] = 1'b0;

    for (genvar i = 0; i < ERR_N; i++) begin : g_err
        assign any_err[i+1] = any_err[i] | err_flags[i];
    end

    assign clean = !any_err[ERR_N];

endmodule

// File: rtl/rxs_addr_screen.sv
module rxs_addr_screen
    import rxs_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [2:0]        match_code,
    input  logic [ADDR_W-1:0] dest_addr,
    output logic              accepted,
    output logic              all_ones_dest
);

    always_comb begin
        unique case (match_code)
            MATCH_UNICAST,
            MATCH_BROADCAST,
            MATCH_MULTICAST,
            MATCH_PROMISC:   accepted = 1'b1;
            default:         accepted = 1'b0;
        endcase
    end

    assign all_ones_dest = &dest_addr;

endmodule

// File: rtl/rxs_port_gate.sv
module rxs_port_gate #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 2
) (
    input  logic                 emit,
    input  logic                 good,
    input  logic                 bcast,
    input  logic [PORT_W-1:0]    port,
    input  logic [NUM_PORTS-1:0] port_en,
    output logic [NUM_PORTS-1:0] good_strobe,
    output logic [NUM_PORTS-1:0] bcast_strobe
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel             = emit && (port == PORT_W'(p)) && port_en[p];
        assign good_strobe[p]  = sel && good;
        assign bcast_strobe[p] = sel && good && bcast;
    end

endmodule

// File: rtl/rxs_frame_classifier.sv
module rxs_frame_classifier
    import rxs_pkg::*;
#(
    parameter int  NUM_PORTS = 3,
    parameter int  LEN_W     = 14,
    parameter int  ADDR_W    = 48,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eof_valid,
    input  logic [PORT_W-1:0]    eof_port,
    input  logic [2:0]           match_code,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic [LEN_W-1:0]     max_len,
    input  logic                 crc_err,
    input  logic                 align_err,
    input  logic                 code_err,
    input  logic                 overrun,
    input  logic [ADDR_W-1:0]    dest_addr,
    input  logic [NUM_PORTS-1:0] port_en,
    output logic [NUM_PORTS-1:0] good_strobe,
    output logic [NUM_PORTS-1:0] bcast_strobe
);

    localparam int ERR_N = 3;

    // Overrun is part of the status word but takes no part in the verdict.
    logic unused_overrun_sink;
    assign unused_overrun_sink = overrun;

    // ---------------- combinational screens ----------------
    logic len_short, len_long, len_ok;
    logic err_clean;
    logic addr_ok, dest_bcast;

    rxs_len_window #(.LEN_W(LEN_W)) u_len (
        .frame_len (frame_len),
        .max_len   (max_len),
        .too_short (len_short),
        .too_long  (len_long),
        .in_window (len_ok)
    );

    rxs_error_screen #(.ERR_N(ERR_N)) u_err (
        .err_flags ({code_err, align_err, crc_err}),
        .clean     (err_clean)
    );

    rxs_addr_screen #(.ADDR_W(ADDR_W)) u_addr (
        .match_code    (match_code),
        .dest_addr     (dest_addr),
        .accepted      (addr_ok),
        .all_ones_dest (dest_bcast)
    );

    rxs_verdict_t verdict_d;

    always_comb begin
        verdict_d.good  = addr_ok && len_ok && err_clean;
        verdict_d.bcast = addr_ok && len_ok && err_clean && dest_bcast;
    end

    // ---------------- control state machine ----------------
    rxs_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = eof_valid ? ST_EMIT : ST_IDLE;   // T_CAPTURE / T_WAIT
            ST_EMIT: st_d = eof_valid ? ST_EMIT : ST_IDLE;   // T_CHAIN / T_RETIRE
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- verdict capture at end of frame ----------------
    rxs_verdict_t         verdict_q;
    logic [PORT_W-1:0]    port_q;
    logic [NUM_PORTS-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
            port_q    <= '0;
            en_q      <= '0;
        end else if (eof_valid) begin
            verdict_q <= verdict_d;
            port_q    <= eof_port;
            en_q      <= port_en;
        end
    end

    // ---------------- outputs ----------------
    logic emit;

    always_comb begin
        unique case (st_q)
            ST_EMIT: emit = 1'b1;
            default: emit = 1'b0;
        endcase
    end

    rxs_port_gate #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_gate (
        .emit         (emit),
        .good         (verdict_q.good),
        .bcast        (verdict_q.bcast),
        .port         (port_q),
        .port_en      (en_q),
        .good_strobe  (good_strobe),
        .bcast_strobe (bcast_strobe)
    );

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
    parameter int NUM_PORTS = 3,
    parameter int LEN_W     = 14,
    parameter int ADDR_W    = 48,
    parameter int PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 eof_valid,
    input logic [PORT_W-1:0]    eof_port,
    input logic [LEN_W-1:0]     frame_len,
    input logic [LEN_W-1:0]     max_len,
    input logic                 crc_err,
    input logic                 align_err,
    input logic                 code_err,
    input logic [ADDR_W-1:0]    dest_addr,
    input logic [NUM_PORTS-1:0] good_strobe,
    input logic [NUM_PORTS-1:0] bcast_strobe
);

    // R2: a strobe appears only in the cycle after an end-of-frame
    assert_strobe_follows_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (good_strobe != '0) |-> $past(eof_valid));

    // R2: no end-of-frame means no strobe in the next cycle
    assert_quiet_without_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_valid |=> (good_strobe == '0) && (bcast_strobe == '0));

    // R4: short or overlong frames never count as good
    assert_len_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid && ((frame_len < LEN_W'(64)) || (frame_len > max_len)) |=> (good_strobe == '0));

    // R5: any receive error suppresses the good strobe
    assert_error_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid && (crc_err || align_err || code_err) |=> (good_strobe == '0));

    // R7: broadcast strobe is a subset of good strobe
    assert_bcast_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_strobe & ~good_strobe) == '0);

    // R7: a non-broadcast destination never gives a broadcast strobe
    assert_bcast_needs_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid && !(&dest_addr) |=> (bcast_strobe == '0));

    // R8: an out-of-range port index gives nothing
    assert_port_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_valid && (int'(eof_port) >= NUM_PORTS) |=> (good_strobe == '0));

    // R10: at most one port strobed at a time
    assert_onehot_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(good_strobe));

endmodule

bind rxs_frame_classifier rxs_checker #(
    .NUM_PORTS (NUM_PORTS),
    .LEN_W     (LEN_W),
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eof_valid    (eof_valid),
    .eof_port     (eof_port),
    .frame_len    (frame_len),
    .max_len      (max_len),
    .crc_err      (crc_err),
    .align_err    (align_err),
    .code_err     (code_err),
    .dest_addr    (dest_addr),
    .good_strobe  (good_strobe),
    .bcast_strobe (bcast_strobe)
);

// File: tb/sim_rxs_frame_classifier.sv
`timescale 1ns/1ps
module sim_rxs_frame_classifier;

    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UC = 48'h0012_3456_789A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof_valid = 1'b0;
    logic [1:0]  eof_port = '0;
    logic [2:0]  match_code = '0;
    logic [13:0] frame_len = '0;
    logic [13:0] max_len = 14'd1518;
    logic        crc_err = 1'b0, align_err = 1'b0, code_err = 1'b0, overrun = 1'b0;
    logic [47:0] dest_addr = '0;
    logic [2:0]  port_en = '0;
    logic [2:0]  good_strobe, bcast_strobe;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rxs_frame_classifier u0 (
        .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_port(eof_port),
        .match_code(match_code), .frame_len(frame_len), .max_len(max_len),
        .crc_err(crc_err), .align_err(align_err), .code_err(code_err),
        .overrun(overrun), .dest_addr(dest_addr), .port_en(port_en),
        .good_strobe(good_strobe), .bcast_strobe(bcast_strobe)
    );

    task automatic check(string req, logic [2:0] g_exp, logic [2:0] b_exp);
        total++;
        if (good_strobe !== g_exp || bcast_strobe !== b_exp) begin
            bad++;
            $display("FAIL %s: good=%b bcast=%b expected good=%b bcast=%b",
                     req, good_strobe, bcast_strobe, g_exp, b_exp);
        end
    endtask

    // Reference verdict built from the requirements.
    function automatic logic [5:0] model(int port, int mc, int len, int mx,
                                         bit ce, bit ae, bit de,
                                         logic [47:0] da, logic [2:0] en);
        bit good;
        logic [2:0] g, b;
        good = (port < 3) && (mc >= 1 && mc <= 4) && (len >= 64) && (len <= mx)
               && !ce && !ae && !de && en[port % 4 < 3 ? port : 0] && (port < 3);
        g = good ? 3'(1 << port) : 3'b000;
        b = (good && da == BC) ? g : 3'b000;
        return {g, b};
    endfunction

    task automatic present(int port, int mc, int len, int mx, bit ce, bit ae,
                           bit de, bit ov, logic [47:0] da, logic [2:0] en);
        eof_valid = 1'b1; eof_port = 2'(port); match_code = 3'(mc);
        frame_len = 14'(len); max_len = 14'(mx); crc_err = ce; align_err = ae;
        code_err = de; overrun = ov; dest_addr = da; port_en = en;
    endtask

    // One frame: strobe in the next cycle, then silence.
    task automatic frame(string req, int port, int mc, int len, int mx, bit ce,
                         bit ae, bit de, bit ov, logic [47:0] da, logic [2:0] en);
        logic [5:0] e;
        e = model(port, mc, len, mx, ce, ae, de, da, en);
        @(negedge clk);
        present(port, mc, len, mx, ce, ae, de, ov, da, en);
        @(posedge clk); #1;
        check(req, e[5:3], e[2:0]);
        @(negedge clk);
        eof_valid = 1'b0;
        @(posedge clk); #1;
        check({req, " R2 single cycle"}, 3'b000, 3'b000);
    endtask

    task automatic t_reset;
        #1 check("R1 in reset", 3'b000, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", 3'b000, 3'b000);
    endtask

    task automatic t_match_codes;
        for (int mc = 0; mc < 8; mc++)
            frame("R3 match code", 1, mc, 100, 1518, 0, 0, 0, 0, UC, 3'b111);
    endtask

    task automatic t_length;
        frame("R4 len 63", 0, 1, 63, 1518, 0, 0, 0, 0, UC, 3'b111);
        frame("R4 len 64", 0, 1, 64, 1518, 0, 0, 0, 0, UC, 3'b111);
        frame("R4 len max", 0, 1, 1518, 1518, 0, 0, 0, 0, UC, 3'b111);
        frame("R4 len max+1", 0, 1, 1519, 1518, 0, 0, 0, 0, UC, 3'b111);
        frame("R4 small max", 2, 3, 80, 79, 0, 0, 0, 0, UC, 3'b111);
    endtask

    task automatic t_errors;
        for (int m = 1; m < 8; m++)
            frame("R5 error combo", 0, 1, 200, 1518, m[0], m[1], m[2], 0, UC, 3'b111);
    endtask

    task automatic t_overrun;
        frame("R6 overrun good", 2, 1, 300, 1518, 0, 0, 0, 1, UC, 3'b111);
        frame("R6 overrun bcast", 1, 2, 300, 1518, 0, 0, 0, 1, BC, 3'b111);
    endtask

    task automatic t_broadcast;
        frame("R7 bcast dest", 0, 2, 64, 1518, 0, 0, 0, 0, BC, 3'b111);
        frame("R7 bcast code, unicast dest", 0, 2, 64, 1518, 0, 0, 0, 0, UC, 3'b111);
        frame("R7 promisc all-ones dest", 2, 4, 500, 1518, 0, 0, 0, 0, BC, 3'b111);
        frame("R7 bcast with crc error", 1, 2, 500, 1518, 1, 0, 0, 0, BC, 3'b111);
    endtask

    task automatic t_port_enable;
        frame("R8 port1 disabled", 1, 1, 100, 1518, 0, 0, 0, 0, BC, 3'b101);
        frame("R8 port2 enabled only", 2, 1, 100, 1518, 0, 0, 0, 0, BC, 3'b100);
        frame("R8 port index 3", 3, 1, 100, 1518, 0, 0, 0, 0, BC, 3'b111);
        for (int p = 0; p < 3; p++)
            frame("R10 port select", p, 3, 128, 1518, 0, 0, 0, 0, UC, 3'b111);
    endtask

    task automatic t_sample_point;
        @(negedge clk);
        present(1, 1, 100, 100, 0, 0, 0, 0, BC, 3'b010);
        @(posedge clk); #1;
        max_len = 14'd64; port_en = 3'b000; dest_addr = UC; crc_err = 1'b1;
        eof_valid = 1'b0;
        #0.5 check("R9 inputs changed in strobe cycle", 3'b010, 3'b010);
        @(posedge clk); #1;
        crc_err = 1'b0;
        check("R9 retire", 3'b000, 3'b000);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        present(0, 1, 100, 1518, 0, 0, 0, 0, BC, 3'b111);
        @(posedge clk); #1;
        check("R2 first of pair", 3'b001, 3'b001);
        @(negedge clk);
        present(2, 1, 40, 1518, 0, 0, 0, 0, BC, 3'b111);
        @(posedge clk); #1;
        check("R2 second of pair rejected", 3'b000, 3'b000);
        @(negedge clk);
        present(2, 3, 90, 1518, 0, 0, 0, 0, UC, 3'b111);
        @(posedge clk); #1;
        check("R2 third in chain", 3'b100, 3'b000);
        @(negedge clk);
        eof_valid = 1'b0;
        @(posedge clk); #1;
        check("R2 chain end", 3'b000, 3'b000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_match_codes();
                t_length();
                t_errors();
                t_overrun();
                t_broadcast();
                t_port_enable();
                t_sample_point();
                t_back_to_back();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule